// File: doc/BRIEF.md
# Profile-Based Output Amplitude Selector

This block supplies the 12-bit amplitude word for a DDS datapath. It keeps eight profile registers, each holding an amplitude scale factor, and a small control register with two enables for output shift keying (OSK). A 3-bit profile select input picks which profile's scale factor is used. An external keying pin can gate the amplitude to zero.

While OSK is enabled, the OSK path owns the amplitude word and overrides every other amplitude source. If the external enable is also set, the keying pin chooses between zero and the selected scale factor. While OSK is disabled, a pass-through amplitude from the rest of the datapath is forwarded unchanged. A synchronous write port loads the profile and control registers. The keying pin and the profile select come from outside the clock domain, so both pass through two synchronizing flops. The output word is registered.

Top module: `amp_profile_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registers clear. After that edge `amp_out` is 0, OSK is disabled and the pass-through source is selected.
- R2: With the OSK enable bit at 0, `amp_out` equals the `amp_bypass` value sampled one edge earlier. The external enable bit, `osk_pin` and `prof_sel` have no effect.
- R3: With OSK enable at 1 and external enable at 0, `amp_out` equals the selected profile's scale factor at every level of `osk_pin`.
- R4: With both enables at 1 and the synchronized `osk_pin` at 0, `amp_out` is 0.
- R5: With both enables at 1 and the synchronized `osk_pin` at 1, `amp_out` equals the selected profile's scale factor.
- R6: A write to a profile stores `wr_data[27:16]` as its scale factor. All other data bits are discarded.
- R7: Write addresses 0 to 7 select profiles 0 to 7. Address 8 is the control register, with OSK enable in `wr_data[8]` and external enable in `wr_data[9]`. Writes to addresses 9 to 15 change nothing.
- R8: A change on `osk_pin` or `prof_sel` reaches `amp_out` on the third rising edge after it, and not earlier.
- R9: A register write takes effect in `amp_out` at the rising edge that follows the edge where `wr_en` was sampled high.
- R10: With `wr_en` low, no register changes, whatever `wr_addr` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0-7 profiles, 8 control |
| wr_data | input | 32 | Write data |
| prof_sel | input | 3 | Profile select, asynchronous |
| osk_pin | input | 1 | External keying pin, asynchronous |
| amp_bypass | input | 12 | Amplitude from the other sources |
| amp_out | output | 12 | Amplitude word to the DDS |

## Verification
The assertions check on every cycle that reset clears the output and the control state. They also check that the pass-through path, the internal-only OSK path and the pin-gated zero each appear one edge after their conditions. Finally they check that the control register holds its value when no control write occurs. Only the bench scenarios can show the exact three-edge latency of the pin and select, and that bits outside the scale field and writes to unused addresses are dropped. The bench also checks that a register write shows up one edge after the strobe, using a reference model that runs across random writes, selects, pin toggles and bypass values.

// File: rtl/amp_sel_pkg.sv
// Shared types for the amplitude selector.
// Assumes: consumers use amp_src_e only for the output source choice.
package amp_sel_pkg;
    typedef enum logic [1:0] {
        SRC_BYPASS  = 2'd0,
        SRC_PROFILE = 2'd1,
        SRC_ZERO    = 2'd2
    } amp_src_e;
endpackage

// File: rtl/amp_sync.sv
// Two-flop synchronizer for a bus of independent asynchronous inputs.
// Assumes: each bit is treated on its own, so no multi-bit coherence is guaranteed.
module amp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two register stages; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/amp_regs.sv
// Profile and control register file with a synchronous write port.
// Assumes: addresses below NUM_PROF hit profiles, address NUM_PROF hits the
// control register, and all higher addresses are unused.
module amp_regs #(
    parameter int AMP_W      = 12,
    parameter int NUM_PROF   = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int SCALE_LSB  = 16,
    parameter int OSK_EN_BIT = 8,
    parameter int EXT_EN_BIT = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [NUM_PROF-1:0][AMP_W-1:0]  prof_scale,
    output logic                            osk_en,
    output logic                            ext_en
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PROF);

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);

    // One scale-factor register per profile.
    for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
        always_ff @(posedge clk) begin
            if (!rst_n)
                prof_scale[p] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(p)))
                prof_scale[p] <= wr_data[SCALE_LSB +: AMP_W];
        end
    end

    // Control register holding the two keying enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osk_en <= 1'b0;
            ext_en <= 1'b0;
        end else if (ctrl_hit) begin
            osk_en <= wr_data[OSK_EN_BIT];
            ext_en <= wr_data[EXT_EN_BIT];
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == CTRL_ADDR)) |=> $stable({osk_en, ext_en})); // R10
endmodule

// File: rtl/amp_out_mux.sv
// Picks the amplitude source and registers the output word.
// Assumes: pin and scale inputs are already synchronous to clk.
module amp_out_mux
    import amp_sel_pkg::*;
#(
    parameter int AMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osk_en,
    input  logic             ext_en,
    input  logic             pin_s,
    input  logic [AMP_W-1:0] scale_sel,
    input  logic [AMP_W-1:0] amp_bypass,
    output logic [AMP_W-1:0] amp_out
);
    amp_src_e src;

    // Source priority: keying path first, pass-through last.
    always_comb begin
        if (!osk_en)
            src = SRC_BYPASS;
        else if (ext_en && !pin_s)
            src = SRC_ZERO;
        else
            src = SRC_PROFILE;
    end

    // Output register driven from the chosen source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            amp_out <= '0;
        else begin
            case (src)
                SRC_PROFILE: amp_out <= scale_sel;
                SRC_ZERO:    amp_out <= '0;
                default:     amp_out <= amp_bypass;
            endcase
        end
    end

    AST_ZERO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (osk_en && ext_en && !pin_s) |=> (amp_out == '0)); // R4
    AST_PIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (osk_en && ext_en && pin_s) |=> (amp_out == $past(scale_sel))); // R5
endmodule

// File: rtl/amp_profile_select.sv
// Top of the amplitude selector: synchronizers, register file, output mux.
// Assumes: prof_sel and osk_pin are asynchronous, everything else is on clk.
module amp_profile_select #(
    parameter int AMP_W      = 12,
    parameter int NUM_PROF   = 8,
    parameter int DATA_W     = 32,
    parameter int SCALE_LSB  = 16,
    parameter int OSK_EN_BIT = 8,
    parameter int EXT_EN_BIT = 9,
    localparam int SEL_W     = $clog2(NUM_PROF),
    localparam int ADDR_W    = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  prof_sel,
    input  logic              osk_pin,
    input  logic [AMP_W-1:0]  amp_bypass,
    output logic [AMP_W-1:0]  amp_out
);
    logic [SEL_W:0]                   sync_in, sync_out;
    logic [SEL_W-1:0]                 sel_s;
    logic                             pin_s;
    logic [NUM_PROF-1:0][AMP_W-1:0]   prof_scale;
    logic                             osk_en, ext_en;
    logic [AMP_W-1:0]                 scale_sel;

    assign sync_in = {osk_pin, prof_sel};
    assign sel_s   = sync_out[SEL_W-1:0];
    assign pin_s   = sync_out[SEL_W];

    amp_sync #(.W(SEL_W + 1)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sync_in),
        .d_sync  (sync_out)
    );

    amp_regs #(
        .AMP_W      (AMP_W),
        .NUM_PROF   (NUM_PROF),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .SCALE_LSB  (SCALE_LSB),
        .OSK_EN_BIT (OSK_EN_BIT),
        .EXT_EN_BIT (EXT_EN_BIT)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .prof_scale (prof_scale),
        .osk_en     (osk_en),
        .ext_en     (ext_en)
    );

    // Scale factor of the profile chosen by the synchronized select.
    always_comb begin
        scale_sel = prof_scale[sel_s];
    end

    amp_out_mux #(.AMP_W(AMP_W)) i_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .osk_en     (osk_en),
        .ext_en     (ext_en),
        .pin_s      (pin_s),
        .scale_sel  (scale_sel),
        .amp_bypass (amp_bypass),
        .amp_out    (amp_out)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (amp_out == '0 && !osk_en)); // R1
    AST_BYPASS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !osk_en |=> (amp_out == $past(amp_bypass))); // R2
    AST_INT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (osk_en && !ext_en) |=> (amp_out == $past(scale_sel))); // R3
endmodule

// File: tb/test_amp_profile_select.sv
// Self-checking bench: reference model plus directed and random stimulus.
module test_amp_profile_select;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  prof_sel = '0;
    logic        osk_pin = 1'b0;
    logic [11:0] amp_bypass = '0;
    logic [11:0] amp_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit auto_on = 0;

    always #(CLK_P/2) clk = ~clk;

    amp_profile_select i_amp_profile_select (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prof_sel(prof_sel), .osk_pin(osk_pin),
        .amp_bypass(amp_bypass), .amp_out(amp_out)
    );

    // Reference model state
    logic [11:0] m_prof [8];
    logic        m_en, m_ext;
    logic        m_pin1, m_pin2;
    logic [2:0]  m_sel1, m_sel2;
    logic [11:0] m_exp;
    string       m_tag;

    function automatic logic [11:0] exp_amp(input logic en, input logic ext,
            input logic pin, input logic [11:0] scale, input logic [11:0] byp);
        if (!en) return byp;              // R2
        if (ext && !pin) return 12'd0;    // R4
        return scale;                     // R3 / R5
    endfunction

    function automatic string tag_of(input logic en, input logic ext, input logic pin);
        if (!en) return "R2";
        if (!ext) return "R3";
        if (!pin) return "R4";
        return "R5";
    endfunction

    // Model: writes (R6, R7, R10), 2-stage sync (R8), registered output (R9)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_prof[i] <= '0;
            m_en <= 0; m_ext <= 0;
            m_pin1 <= 0; m_pin2 <= 0; m_sel1 <= 0; m_sel2 <= 0;
            m_exp <= '0; m_tag <= "R1";
        end else begin
            if (wr_en && wr_addr < 4'd8) m_prof[wr_addr[2:0]] <= wr_data[27:16];
            if (wr_en && wr_addr == 4'd8) begin
                m_en <= wr_data[8]; m_ext <= wr_data[9];
            end
            m_pin1 <= osk_pin; m_pin2 <= m_pin1;
            m_sel1 <= prof_sel; m_sel2 <= m_sel1;
            m_exp <= exp_amp(m_en, m_ext, m_pin2, m_prof[m_sel2], amp_bypass);
            m_tag <= tag_of(m_en, m_ext, m_pin2);
        end
    end

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: amp_out=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (auto_on && !done) check({m_tag, " (model)"}, amp_out, m_exp);
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = $urandom;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1D5E);
        @(negedge clk); @(negedge clk);
        check("R1 reset", amp_out, 12'd0);
        rst_n = 1;
        auto_on = 1;
        amp_bypass = 12'hA5C;
        @(negedge clk);
        check("R1 bypass after reset", amp_out, 12'hA5C); // R1, R2

        // R6/R7: load profiles with junk outside [27:16]
        for (int p = 0; p < 8; p++)
            wr(4'(p), {4'hF, 12'(12'h100 + p * 12'h111), 16'hFFFF});
        // R7: unused addresses must not touch anything
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        // R10: strobe low with control address
        wr_addr = 4'd8; wr_data = 32'h0000_0300; idle(3);
        check("R10 ctrl unchanged", amp_out, amp_bypass);

        // R9: enable OSK internal only, visible one edge after strobe edge
        prof_sel = 3'd5; osk_pin = 0; idle(3);
        wr_en = 1; wr_addr = 4'd8; wr_data = 32'h0000_0100;
        @(posedge clk); #1 wr_en = 0;
        @(posedge clk); #1;
        check("R9 write latency", amp_out, 12'h100 + 5 * 12'h111);
        check("R6 scale field", amp_out, 12'h655);
        @(negedge clk);
        // R3: pin toggles have no effect
        osk_pin = 1; idle(4);
        check("R3 pin ignored", amp_out, 12'h655);

        // R8: both enables, pin held high, then drop
        wr(4'd8, 32'h0000_0300); idle(3);
        check("R5 pin high", amp_out, 12'h655);
        osk_pin = 0;
        @(posedge clk); #1 check("R8 edge1", amp_out, 12'h655);
        @(posedge clk); #1 check("R8 edge2", amp_out, 12'h655);
        @(posedge clk); #1 check("R8 edge3", amp_out, 12'h000); // R4
        @(negedge clk);
        osk_pin = 1; idle(3);
        prof_sel = 3'd2;
        @(posedge clk); #1 check("R8 sel edge2a", amp_out, 12'h655);
        @(posedge clk); #1 check("R8 sel edge2b", amp_out, 12'h655);
        @(posedge clk); #1 check("R8 sel edge3", amp_out, 12'h322);
        @(negedge clk);

        // R7: unused address write kept profile 2
        wr(4'd12, 32'h0ABC_0000); idle(3);
        check("R7 unused addr", amp_out, 12'h322);

        // Random phases, one per control combination
        for (int ph = 0; ph < 4; ph++) begin
            wr(4'd8, 32'(ph) << 8);
            for (int c = 0; c < 1500; c++) begin
                wr_en = ($urandom_range(0, 7) == 0);
                wr_addr = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(9, 15))
                                                      : 4'($urandom_range(0, 7));
                wr_data = $urandom;
                if ($urandom_range(0, 3) == 0) prof_sel = 3'($urandom);
                if ($urandom_range(0, 2) == 0) osk_pin = ~osk_pin;
                amp_bypass = 12'($urandom);
                @(negedge clk);
            end
            wr_en = 0;
        end

        // Reset mid-run clears state (R1)
        rst_n = 0; idle(2);
        check("R1 mid-run reset", amp_out, 12'd0);
        rst_n = 1; amp_bypass = 12'h3C3; idle(2);
        check("R1 bypass selected", amp_out, 12'h3C3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule